// File: doc/BRIEF.md
# Paged Edge-Detect GPIO Controller

This block controls 48 digital lines grouped into six 8-bit ports and is reached from a byte-wide host register bus. Each line behaves as an open-drain output. Setting a data bit pulls the pin low, and clearing it releases the pin so that it can serve as an input. A port read returns the synchronised pin level inverted, so a high pin reads as 0. A per-port lock bit protects each data register from writes.

The three lowest ports also watch their lines for edges. Each line has a polarity bit that selects a rising or a falling edge, and an enable bit. An enabled edge of the selected polarity latches an identification bit, which stays set until the host clears it by writing 0 to it. A summary byte shows which edge ports hold set bits. One interrupt output stays high while any identification bit is set.

Polarity, enable and identification bytes share one three-byte window at offsets 8 to 10. The page field of the control register chooses which of them the window shows. That field is a four-state machine:

- `PG_NONE` (0): the window maps nothing.
- `PG_POL` (1): the window shows the polarity bytes.
- `PG_ENAB` (2): the window shows the enable bytes.
- `PG_ID` (3): the window shows the identification bytes.

A write to offset 7 moves the machine from any state to the state named by data bits 7:6, including back to the state it is already in. No other event changes the page.

Top module: `paged_gpio`

## Requirements
- R1: After reset, every port data, polarity, enable and identification register is zero, the page is `PG_NONE`, and all lock bits are 0. `pin_pull_low` and `irq` are 0, and the synchronisers hold the released (high) level, so lines that stay high raise no edge.
- R2: A write to offset p (0 to 5) stores the data byte for port p, whatever the page. Bit i of that byte drives `pin_pull_low[8p+i]`, where 1 pulls the pin low and 0 releases it.
- R3: A read of offset p (0 to 5) returns the inverted pin level of port p, sampled through a two-flop synchroniser. A pin change made before a clock edge shows in the read after the second rising edge.
- R4: Offset 7 holds the page in bits 7:6 and the lock bit of port p in bit p (bits 5:0). A write sets both, and a read returns both.
- R5: While the lock bit of port p is 1, writes to offset p leave that port's data unchanged. Writes to unlocked ports still take effect.
- R6: Offsets 8, 9 and 10 reach edge ports 0, 1 and 2. Page 1 maps polarity, page 2 enable and page 3 identification. In page 0 the window reads 0x00, and writes to it change nothing.
- R7: An enabled line whose polarity bit is 1 latches its identification bit on a rising pin edge, and one whose polarity bit is 0 latches on a falling edge. An edge of the other direction is ignored. The bit is set after the third rising clock edge following the pin change.
- R8: A line whose enable bit is 0 never sets its identification bit, whatever its pin does.
- R9: A write to an identification byte (page 3) clears the bits where the data is 0 and keeps those where it is 1. If an edge is detected in the same cycle as a clearing write, the edge wins and the bit ends set.
- R10: Offset 6 bit k (k = 0 to 2) is 1 when any identification bit of port k is set, and bits 7:3 read 0. `irq` is 1 when any identification bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 48 | Pin levels, port p at bits 8p+7:8p |
| pin_pull_low | output | 48 | Open-drain pull-down enables, same layout as `pin_in` |
| irq | output | 1 | High while any identification bit is set |

## Verification
A wrong page state shows on the next read of offsets 8 to 10 as the wrong bank or as a non-zero value in page 0. It also shows as a window write that lands in the wrong bank, which a later read in the correct page exposes. A faulty synchroniser or previous-sample register changes the cycle in which a port read shows the new level, or the cycle in which `irq` rises after a pin change. The bench samples the cycle just before and the cycle just after each expected change. A faulty clear or set path shows in the next read of the identification byte and in the summary byte. The collision case, where an edge meets a clearing write in the same cycle, shows up only if the bench lines the two up on the same clock edge, so the bench does exactly that.

// File: rtl/pgio_pkg.sv
package pgio_pkg;
    typedef enum logic [1:0] {
        PG_NONE = 2'd0,
        PG_POL  = 2'd1,
        PG_ENAB = 2'd2,
        PG_ID   = 2'd3
    } page_e;

    localparam int ADDR_W   = 4;
    localparam int OFS_PEND = 6;
    localparam int OFS_CTRL = 7;
    localparam int WIN_BASE = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] lvl
);
    logic [W-1:0] meta_q;
    logic [W-1:0] lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            lvl_q  <= '1;
        end else begin
            meta_q <= pin;
            lvl_q  <= meta_q;
        end
    end

    assign lvl = lvl_q;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] wdata,
    input  logic         we_pol,
    input  logic         we_enab,
    input  logic         we_id,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] enab_q,
    output logic [W-1:0] id_q
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] fall;
    logic [W-1:0] hit;
    logic [W-1:0] id_d;

    always_comb begin
        rise = lvl & ~prev_q;
        fall = ~lvl & prev_q;
        hit  = enab_q & ((pol_q & rise) | (~pol_q & fall));
        if (we_id) id_d = (id_q & wdata) | hit;
        else       id_d = id_q | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
            pol_q  <= '0;
            enab_q <= '0;
            id_q   <= '0;
        end else begin
            prev_q <= lvl;
            if (we_pol)  pol_q  <= wdata;
            if (we_enab) enab_q <= wdata;
            id_q <= id_d;
        end
    end

    // R8: newly set bits appear only on enabled lines
    a_r8_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((id_q & ~$past(id_q) & ~$past(enab_q)) == '0));

    // R9: a clearing write keeps the bits written as 1
    a_r9_ones_keep: assert property (@(posedge clk) disable iff (!rst_n)
        we_id |=> ((($past(id_q) & $past(wdata)) & ~id_q) == '0));

    // R9: a detected edge always ends with its bit set, even during a clear
    a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((id_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/paged_gpio.sv
module paged_gpio
    import pgio_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int NUM_EDGE  = 3,
    parameter int PORT_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [3:0]                  bus_addr,
    input  logic                        bus_wr,
    input  logic [PORT_W-1:0]           bus_wdata,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    output logic [NUM_PORTS*PORT_W-1:0] pin_pull_low,
    output logic                        irq
);
    localparam int PAGE_LSB = PORT_W - 2;

    page_e                 page_q, page_d;
    logic                  sel_pol, sel_enab, sel_id;
    logic [NUM_PORTS-1:0]  lock_q;
    logic                  ctrl_we;

    logic [PORT_W-1:0] lvl_a  [NUM_PORTS];
    logic [PORT_W-1:0] drv_q  [NUM_PORTS];
    logic [PORT_W-1:0] pol_a  [NUM_EDGE];
    logic [PORT_W-1:0] enab_a [NUM_EDGE];
    logic [PORT_W-1:0] id_a   [NUM_EDGE];
    logic [NUM_EDGE-1:0] pend;

    assign ctrl_we = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));

    // ---------------- page state machine: next state ----------------
    always_comb begin
        page_d = page_q;
        if (ctrl_we) page_d = page_e'(bus_wdata[PORT_W-1:PAGE_LSB]);
    end

    // ---------------- page state machine: state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= PG_NONE;
            lock_q <= '0;
        end else begin
            page_q <= page_d;
            if (ctrl_we) lock_q <= bus_wdata[NUM_PORTS-1:0];
        end
    end

    // ---------------- page state machine: outputs ----------------
    always_comb begin
        sel_pol  = 1'b0;
        sel_enab = 1'b0;
        sel_id   = 1'b0;
        unique case (page_q)
            PG_NONE: ;
            PG_POL:  sel_pol  = 1'b1;
            PG_ENAB: sel_enab = 1'b1;
            PG_ID:   sel_id   = 1'b1;
        endcase
    end

    // ---------------- data ports ----------------
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic port_we;
        assign port_we = bus_wr && (bus_addr == ADDR_W'(p)) && !lock_q[p];

        gpio_sync #(.W(PORT_W)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_in[p*PORT_W +: PORT_W]),
            .lvl   (lvl_a[p])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       drv_q[p] <= '0;
            else if (port_we) drv_q[p] <= bus_wdata;
        end

        assign pin_pull_low[p*PORT_W +: PORT_W] = drv_q[p];

        // R5: a locked port keeps its data through a write
        a_r5_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && (bus_addr == ADDR_W'(p)) && lock_q[p]) |=> $stable(drv_q[p]));
    end

    // ---------------- edge-capable ports ----------------
    for (genvar e = 0; e < NUM_EDGE; e++) begin : g_edge
        logic win_hit;
        assign win_hit = bus_wr && (bus_addr == ADDR_W'(WIN_BASE + e));

        gpio_edge_bank #(.W(PORT_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (lvl_a[e]),
            .wdata   (bus_wdata),
            .we_pol  (win_hit && sel_pol),
            .we_enab (win_hit && sel_enab),
            .we_id   (win_hit && sel_id),
            .pol_q   (pol_a[e]),
            .enab_q  (enab_a[e]),
            .id_q    (id_a[e])
        );

        assign pend[e] = |id_a[e];

        // R6: in page 0 no write changes the configuration bytes
        a_r6_page0_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && page_q == PG_NONE) |=> ($stable(pol_a[e]) && $stable(enab_a[e])));
    end

    assign irq = |pend;

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == ADDR_W'(p)) bus_rdata = ~lvl_a[p];
        end
        if (bus_addr == ADDR_W'(OFS_PEND)) begin
            bus_rdata[NUM_EDGE-1:0] = pend;
        end
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            bus_rdata[PORT_W-1:PAGE_LSB] = page_q;
            bus_rdata[NUM_PORTS-1:0]     = lock_q;
        end
        for (int e = 0; e < NUM_EDGE; e++) begin
            if (bus_addr == ADDR_W'(WIN_BASE + e)) begin
                unique case (page_q)
                    PG_NONE: bus_rdata = '0;
                    PG_POL:  bus_rdata = pol_a[e];
                    PG_ENAB: bus_rdata = enab_a[e];
                    PG_ID:   bus_rdata = id_a[e];
                endcase
            end
        end
    end

    // R4: a control write sets the lock bits seen on the next cycle
    a_r4_lock_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (lock_q == $past(bus_wdata[NUM_PORTS-1:0])));

    // R10: with no identification bit set the interrupt is low
    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !irq);
endmodule

// File: tb/test_paged_gpio.sv
module test_paged_gpio;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] ext = '1;
    logic [47:0] pin_in;
    logic [47:0] pull_low;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    assign pin_in = ext & ~pull_low;

    paged_gpio i_paged_gpio (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (addr),
        .bus_wr       (wr),
        .bus_wdata    (wdata),
        .bus_rdata    (rdata),
        .pin_in       (pin_in),
        .pin_pull_low (pull_low),
        .irq          (irq)
    );

    task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_w(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_r(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 pull_low after reset", pull_low, 48'h0);
        chk("R1 irq after reset", {47'h0, irq}, 48'h0);
        for (int a = 0; a <= 10; a++) begin
            bus_r(4'(a), d);
            chk($sformatf("R1 offset %0d after reset", a), {40'h0, d}, 48'h0);
        end
    endtask

    task automatic t_ports;
        logic [7:0] d;
        bus_w(4'd1, 8'hA5);
        chk("R2 port1 drive", {40'h0, pull_low[15:8]}, 48'hA5);
        ticks(2);
        bus_r(4'd1, d);
        chk("R3 port1 reads driven lines low", {40'h0, d}, 48'hA5);
        bus_w(4'd7, 8'hC0);
        bus_w(4'd4, 8'h3C);
        chk("R2 port4 write in page 3", {40'h0, pull_low[39:32]}, 48'h3C);
        bus_w(4'd7, 8'h00);
        ext[47:40] = 8'h0F;
        ticks(1);
        bus_r(4'd5, d);
        chk("R3 port5 one edge after change", {40'h0, d}, 48'h00);
        ticks(1);
        bus_r(4'd5, d);
        chk("R3 port5 two edges after change", {40'h0, d}, 48'hF0);
        ext[47:40] = 8'hFF;
        bus_w(4'd1, 8'h00);
        bus_w(4'd4, 8'h00);
        chk("R2 release", pull_low, 48'h0);
    endtask

    task automatic t_lock;
        logic [7:0] d;
        bus_w(4'd7, 8'h82);
        bus_r(4'd7, d);
        chk("R4 control readback", {40'h0, d}, 48'h82);
        bus_w(4'd1, 8'hFF);
        chk("R5 locked port1 unchanged", {40'h0, pull_low[15:8]}, 48'h00);
        bus_w(4'd0, 8'h11);
        chk("R5 unlocked port0 written", {40'h0, pull_low[7:0]}, 48'h11);
        bus_w(4'd7, 8'h00);
        bus_w(4'd0, 8'h00);
        ticks(2);
    endtask

    task automatic t_page;
        logic [7:0] d;
        bus_w(4'd7, 8'h40);
        bus_w(4'd8, 8'h0F);
        bus_r(4'd8, d);
        chk("R6 polarity readback", {40'h0, d}, 48'h0F);
        bus_w(4'd7, 8'h80);
        bus_r(4'd8, d);
        chk("R6 enable bank separate", {40'h0, d}, 48'h00);
        bus_w(4'd7, 8'h00);
        bus_r(4'd8, d);
        chk("R6 page 0 reads zero", {40'h0, d}, 48'h00);
        bus_w(4'd9, 8'hFF);
        bus_w(4'd7, 8'h40);
        bus_r(4'd9, d);
        chk("R6 page 0 write skips polarity", {40'h0, d}, 48'h00);
        bus_w(4'd7, 8'h80);
        bus_r(4'd9, d);
        chk("R6 page 0 write skips enable", {40'h0, d}, 48'h00);
    endtask

    task automatic t_edges;
        logic [7:0] d;
        bus_w(4'd7, 8'h40);
        bus_w(4'd8, 8'h01);
        bus_w(4'd10, 8'h80);
        bus_w(4'd7, 8'h80);
        bus_w(4'd8, 8'h03);
        bus_w(4'd10, 8'h80);
        bus_w(4'd7, 8'hC0);
        ext[0] = 1'b0;
        ticks(4);
        bus_r(4'd8, d);
        chk("R7 falling edge ignored on rising line", {40'h0, d}, 48'h00);
        ext[0] = 1'b1;
        ticks(2);
        chk("R7 irq not yet after two edges", {47'h0, irq}, 48'h0);
        ticks(1);
        chk("R7 irq after third edge", {47'h0, irq}, 48'h1);
        bus_r(4'd8, d);
        chk("R7 rising edge latched", {40'h0, d}, 48'h01);
        ext[1] = 1'b0;
        ticks(3);
        bus_r(4'd8, d);
        chk("R7 falling edge latched", {40'h0, d}, 48'h03);
        ext[2] = 1'b0;
        ticks(4);
        ext[2] = 1'b1;
        ticks(4);
        bus_r(4'd8, d);
        chk("R8 disabled line ignored", {40'h0, d}, 48'h03);
        bus_r(4'd6, d);
        chk("R10 summary port0 only", {40'h0, d}, 48'h01);
        ext[23] = 1'b0;
        ticks(4);
        ext[23] = 1'b1;
        ticks(3);
        bus_r(4'd6, d);
        chk("R10 summary ports 0 and 2", {40'h0, d}, 48'h05);
        bus_r(4'd10, d);
        chk("R7 port2 line7 latched", {40'h0, d}, 48'h80);
    endtask

    task automatic t_clear;
        logic [7:0] d;
        bus_w(4'd8, 8'hFE);
        bus_r(4'd8, d);
        chk("R9 clear only zero bits", {40'h0, d}, 48'h02);
        bus_w(4'd8, 8'h00);
        bus_r(4'd6, d);
        chk("R10 summary after port0 clear", {40'h0, d}, 48'h04);
        bus_w(4'd10, 8'h00);
        bus_r(4'd6, d);
        chk("R10 summary all clear", {40'h0, d}, 48'h00);
        chk("R10 irq low after clear", {47'h0, irq}, 48'h0);
        ext[23] = 1'b0;
        ticks(4);
        ext[23] = 1'b1;
        ticks(2);
        addr = 4'd10; wdata = 8'h00; wr = 1'b1;
        ticks(1);
        wr = 1'b0;
        bus_r(4'd10, d);
        chk("R9 edge wins over same-cycle clear", {40'h0, d}, 48'h80);
        chk("R9 irq stays high", {47'h0, irq}, 48'h1);
        bus_w(4'd10, 8'h00);
        chk("R9 later clear works", {47'h0, irq}, 48'h0);
    endtask

    initial begin
        ticks(3);
        rst_n = 1'b1;
        ticks(1);
        t_reset();
        t_ports();
        t_lock();
        t_page();
        t_edges();
        t_clear();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule